// File: doc/BRIEF.md
# Serial ADC Scan Sequencer

This block runs an eight-channel, 12-bit serial converter with no software help. Once the host has loaded the per-channel mode registers and set the enable bit, the sequencer converts channel 0, then 1, and so on up to channel 7. It then wraps back to channel 0 and keeps going for as long as enable stays set. For each conversion it builds an 8-bit control word from the channel number and that channel's mode and shifts it out on a divided serial clock. After a short acquisition pause it shifts the 12-bit result back in and stores it in that channel's data register.

The host reaches everything through a small register port. Addresses 0..7 are the per-channel result registers, which are read-only. Addresses 8..15 are the channel mode registers. Address 16 is the control register. Results live in a single-write-port storage array. An arbiter gives the sequencer's write priority over a host read of the same register in the same cycle, so a read never sees a partly updated value. Such a read is delayed by one cycle, and the ready signal shows the delay.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock and data out are low, `host_ready` is low, and the enable bit and all mode registers read back as 0.
- R2: A mode register at address 8+n holds bit 0 = bipolar and bit 1 = range select, and reads back what was written. No frame starts (chip select stays high) while the enable bit (address 16, bit 0) is 0.
- R3: Each frame sends an 8-bit control word MSB first: bit7 = 1, bits6..4 = channel, bit3 = range, bit2 = bipolar, bits1..0 = 00. Data out changes only while the serial clock is low; the converter samples on the rising edge.
- R4: Chip select stays low for exactly 24 serial clocks: 8 control bits, then 4 acquisition clocks, then 12 result bits. The result bits are taken MSB first on rising edges. Between frames, chip select stays high for at least 2 serial clock periods, and the serial clock stays low while chip select is high.
- R5: Channels are converted in the order 0,1,...,7 and then from 0 again, for as long as enable stays set.
- R6: Each result is written to the data register of the channel it was converted from. A read of address n returns that result, zero-extended.
- R7: A read without a collision raises `host_ready` in the cycle after `host_rd` is sampled, with `host_rdata` valid in that cycle.
- R8: If a host read of data register n is sampled in the same cycle as the sequencer writes register n, `host_ready` comes one cycle later than usual and the read returns the newly written value.
- R9: Clearing enable during a frame lets that frame finish and store its result. Chip select then stays high. Setting enable again after the sequencer has reached idle restarts the scan at channel 0.
- R10: Every serial clock half-period lasts HALF_DIV system clock cycles.
- R11: Host writes to data register addresses 0..7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | HOST_W | Write data |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle; no new read until ready |
| host_rdata | output | HOST_W | Read data, valid with host_ready |
| host_ready | output | 1 | Read data valid |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_sdo | output | 1 | Control word bits to converter |
| adc_sdi | input | 1 | Result bits from converter |

## Verification
The bench models the converter on the serial pins and scoreboards every result against the register it should land in, with all-ones and all-zero results among the patterns. An off-by-one bit count or a wrong sampling edge would shift the stored values, and wrong channel stepping would send data to the wrong register. A read is aimed at the exact cycle of a sequencer write to the same register: a design without the arbiter would return stale data or answer on time, and the bench catches both. Enable is also cleared in the middle of a frame. A design that aborts the frame would lose that result, and one that does not reset the channel pointer would restart at the wrong channel.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int CW_W = 8;

  typedef struct packed {
    logic range_sel;
    logic bipolar;
  } ch_mode_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_XFER = 2'd1,
    S_GAP  = 2'd2
  } ser_state_t;

  // start bit, channel, range, polarity, clock mode 00 (external clock)
  function automatic logic [CW_W-1:0] build_ctrl_word(input logic [2:0] ch,
                                                      input ch_mode_t m);
    return {1'b1, ch, m.range_sel, m.bipolar, 2'b00};
  endfunction

endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5,
  parameter int HOST_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [HOST_W-1:0]       wdata,
  output ch_mode_t [NUM_CH-1:0]   mode,
  output logic                    enable,
  output logic                    rvalid,
  output logic [HOST_W-1:0]       rdata
);

  localparam int MODE_BASE = NUM_CH;
  localparam int CTRL_ADDR = 2 * NUM_CH;

  ch_mode_t [NUM_CH-1:0] mode_q;
  logic                  en_q;
  logic [HOST_W-1:0]     rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(MODE_BASE + i)) rd_mux = HOST_W'({mode_q[i]});
    end
    if (addr == ADDR_W'(CTRL_ADDR)) rd_mux = HOST_W'(en_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      en_q   <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_mux;
      if (wr) begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (addr == ADDR_W'(MODE_BASE + i)) mode_q[i] <= wdata[1:0];
        end
        if (addr == ADDR_W'(CTRL_ADDR)) en_q <= wdata[0];
      end
    end
  end

  assign mode   = mode_q;
  assign enable = en_q;

endmodule

// File: rtl/adc_scan_serial.sv
module adc_scan_serial
  import adc_scan_pkg::*;
#(
  parameter int HALF_DIV = 8,
  parameter int ACQ_CLKS = 4,
  parameter int RES_W    = 12,
  parameter int GAP_CLKS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [CW_W-1:0] ctrl_word,
  output logic            cs_n,
  output logic            sclk,
  output logic            sdo,
  input  logic            sdi,
  output logic            busy,
  output logic            done,
  output logic [RES_W-1:0] result
);

  localparam int TOTAL       = CW_W + ACQ_CLKS + RES_W;
  localparam int SAMPLE_FROM = CW_W + ACQ_CLKS;
  localparam int GAP_HALVES  = 2 * GAP_CLKS;
  localparam int BIT_W       = $clog2(TOTAL + 1);
  localparam int DIV_W       = $clog2(HALF_DIV + 1);
  localparam int GAP_W       = $clog2(GAP_HALVES + 1);

  ser_state_t       state;
  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic [GAP_W-1:0] gap_q;
  logic [CW_W-1:0]  tx_q;
  logic [RES_W-1:0] rx_q;
  logic             tick;

  assign tick = (div_q == DIV_W'(HALF_DIV - 1));
  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      div_q  <= '0;
      bit_q  <= '0;
      gap_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      cs_n   <= 1'b1;
      sclk   <= 1'b0;
      sdo    <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          div_q <= '0;
          if (start) begin
            tx_q  <= ctrl_word;
            sdo   <= ctrl_word[CW_W-1];
            cs_n  <= 1'b0;
            bit_q <= '0;
            state <= S_XFER;
          end
        end
        S_XFER: begin
          div_q <= tick ? '0 : div_q + 1'b1;
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
              if (bit_q >= BIT_W'(SAMPLE_FROM)) rx_q <= {rx_q[RES_W-2:0], sdi};
            end else begin
              sclk <= 1'b0;
              tx_q <= {tx_q[CW_W-2:0], 1'b0};
              sdo  <= tx_q[CW_W-2];
              if (bit_q == BIT_W'(TOTAL - 1)) begin
                state  <= S_GAP;
                cs_n   <= 1'b1;
                sdo    <= 1'b0;
                done   <= 1'b1;
                result <= rx_q;
                gap_q  <= '0;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end
        end
        S_GAP: begin
          div_q <= tick ? '0 : div_q + 1'b1;
          if (tick) begin
            if (gap_q == GAP_W'(GAP_HALVES - 1)) state <= S_IDLE;
            else gap_q <= gap_q + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_scan_store.sv
module adc_scan_store #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 12,
  parameter int CH_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CH_W-1:0]  waddr,
  input  logic [RES_W-1:0] wdata,
  input  logic             rd,
  input  logic [CH_W-1:0]  raddr,
  output logic             rvalid,
  output logic [RES_W-1:0] rdata
);

  logic [RES_W-1:0] mem [NUM_CH];
  logic             pend_q;
  logic [CH_W-1:0]  pend_addr_q;
  logic [CH_W-1:0]  rsel;
  logic             req;
  logic             collide;
  logic             do_read;

  assign rsel    = pend_q ? pend_addr_q : raddr;
  assign req     = rd | pend_q;
  assign collide = req & we & (waddr == rsel);
  assign do_read = req & ~collide;

  // storage array: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (do_read) rdata <= mem[rsel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      rvalid      <= 1'b0;
    end else begin
      rvalid <= do_read;
      pend_q <= collide;
      if (collide) pend_addr_q <= rsel;
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int RES_W    = 12,
  parameter int HOST_W   = 16,
  parameter int HALF_DIV = 8,
  parameter int ACQ_CLKS = 4,
  parameter int GAP_CLKS = 2,
  parameter int ADDR_W   = $clog2(2 * NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_ready,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic              adc_sdo,
  input  logic              adc_sdi
);

  localparam int CH_W = $clog2(NUM_CH);

  ch_mode_t [NUM_CH-1:0] mode;
  logic                  enable;
  logic                  data_rd;
  logic                  reg_rd;
  logic                  rg_rvalid;
  logic [HOST_W-1:0]     rg_rdata;
  logic                  st_rvalid;
  logic [RES_W-1:0]      st_rdata;
  logic [CH_W-1:0]       ch_q;
  logic [CW_W-1:0]       ctrl_word;
  logic                  ser_busy;
  logic                  seq_we;
  logic [RES_W-1:0]      seq_res;

  assign data_rd = host_rd && (host_addr < ADDR_W'(NUM_CH));
  assign reg_rd  = host_rd && !(host_addr < ADDR_W'(NUM_CH));

  adc_scan_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .HOST_W(HOST_W)) u_regs (
    .clk(clk), .rst(rst), .wr(host_wr), .rd(reg_rd), .addr(host_addr),
    .wdata(host_wdata), .mode(mode), .enable(enable),
    .rvalid(rg_rvalid), .rdata(rg_rdata)
  );

  assign ctrl_word = build_ctrl_word(3'(ch_q), mode[ch_q]);

  adc_scan_serial #(.HALF_DIV(HALF_DIV), .ACQ_CLKS(ACQ_CLKS), .RES_W(RES_W),
                    .GAP_CLKS(GAP_CLKS)) u_ser (
    .clk(clk), .rst(rst), .start(enable), .ctrl_word(ctrl_word),
    .cs_n(adc_cs_n), .sclk(adc_sclk), .sdo(adc_sdo), .sdi(adc_sdi),
    .busy(ser_busy), .done(seq_we), .result(seq_res)
  );

  // channel pointer: steps on each stored result, rewinds when fully idle
  always_ff @(posedge clk) begin
    if (rst) begin
      ch_q <= '0;
    end else if (seq_we) begin
      ch_q <= (ch_q == CH_W'(NUM_CH - 1)) ? '0 : ch_q + 1'b1;
    end else if (!ser_busy && !enable) begin
      ch_q <= '0;
    end
  end

  adc_scan_store #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_store (
    .clk(clk), .rst(rst), .we(seq_we), .waddr(ch_q), .wdata(seq_res),
    .rd(data_rd), .raddr(host_addr[CH_W-1:0]),
    .rvalid(st_rvalid), .rdata(st_rdata)
  );

  assign host_ready = st_rvalid | rg_rvalid;
  assign host_rdata = st_rvalid ? HOST_W'(st_rdata) : rg_rdata;

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int NUM_CH    = 8,
  parameter int ADDR_W    = 5,
  parameter int CH_W      = 3,
  parameter int GAP_LIMIT = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              sclk,
  input logic              sdo,
  input logic              enable,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_ready,
  input logic              seq_we,
  input logic [CH_W-1:0]   seq_waddr
);

  localparam int GW = $clog2(GAP_LIMIT + 1) + 1;

  logic [GW-1:0] gap_cnt;
  logic          hit;

  assign hit = host_rd && (host_addr < ADDR_W'(NUM_CH)) && seq_we &&
               (host_addr[CH_W-1:0] == seq_waddr);

  always_ff @(posedge clk) begin
    if (rst) gap_cnt <= GW'(GAP_LIMIT);
    else if (!cs_n) gap_cnt <= '0;
    else if (gap_cnt < GW'(GAP_LIMIT)) gap_cnt <= gap_cnt + 1'b1;
  end

  assert_sclk_low_idle_R4: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  assert_cs_gap_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (gap_cnt >= GW'(GAP_LIMIT)));

  assert_sdo_stable_R3: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(sdo));

  assert_start_enabled_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> enable);

  assert_stay_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !enable) |=> cs_n);

  assert_read_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !hit) |=> host_ready);

  assert_collision_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (host_rd && hit) |=> (!host_ready ##1 host_ready));

endmodule

bind adc_scan_seq adc_scan_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W),
  .GAP_LIMIT(2 * GAP_CLKS * HALF_DIV)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(adc_cs_n), .sclk(adc_sclk), .sdo(adc_sdo),
  .enable(enable), .host_rd(host_rd), .host_addr(host_addr),
  .host_ready(host_ready), .seq_we(seq_we), .seq_waddr(ch_q)
);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;

  localparam int NUM_CH = 8;
  localparam int HOST_W = 16;
  localparam int HD     = 2;
  localparam int GAPC   = 2;
  localparam int AW     = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] host_addr = '0;
  logic [HOST_W-1:0] host_wdata = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [HOST_W-1:0] host_rdata;
  logic host_ready;
  logic adc_cs_n, adc_sclk, adc_sdo;
  logic adc_sdi = 1'b0;

  always #4 clk = ~clk;

  adc_scan_seq #(.NUM_CH(NUM_CH), .HOST_W(HOST_W), .HALF_DIV(HD),
                 .ACQ_CLKS(4), .GAP_CLKS(GAPC)) u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .host_ready(host_ready), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_sdo(adc_sdo), .adc_sdi(adc_sdi)
  );

  typedef struct { int ch; logic [11:0] val; } item_t;
  item_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  int exp_ch = 0, frame_cnt = 0, cs_falls = 0;
  int err_half = 0, err_rises = 0, err_gap = 0, err_sdo = 0;
  logic [1:0] mode_exp [NUM_CH];
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input int a, input int d);
    @(negedge clk);
    host_addr = AW'(a); host_wdata = HOST_W'(d); host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input int a, output int d, output int lat);
    @(negedge clk);
    host_addr = AW'(a); host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; lat = 1;
    while (!host_ready && lat < 10) begin @(negedge clk); lat++; end
    d = int'(host_rdata);
  endtask

  function automatic logic [11:0] result_for(input int n);
    if (n == 0) return 12'hFFF;
    if (n == 1) return 12'h000;
    return 12'((n * 613 + 291) ^ (n << 7));
  endfunction

  // converter model: captures control word, returns result, feeds scoreboard
  initial begin
    forever begin
      logic [7:0] w;
      logic [11:0] v;
      @(negedge adc_cs_n);
      w = '0;
      for (int i = 0; i < 8; i++) begin
        @(posedge adc_sclk);
        w = {w[6:0], adc_sdo};
      end
      check(int'(w[6:4]) == exp_ch, "R5 channel order", int'(w[6:4]), exp_ch);
      check(w == {1'b1, 3'(exp_ch), mode_exp[exp_ch], 2'b00}, "R3 control word",
            int'(w), int'({1'b1, 3'(exp_ch), mode_exp[exp_ch], 2'b00}));
      v = result_for(frame_cnt);
      repeat (4) @(posedge adc_sclk);
      for (int i = 0; i < 12; i++) begin
        @(negedge adc_sclk);
        adc_sdi = v[11-i];
      end
      @(posedge adc_cs_n);
      exp_q.push_back('{ch: int'(w[6:4]), val: v});
      exp_ch = (exp_ch + 1) % NUM_CH;
      frame_cnt++;
    end
  end

  // pin-level timing monitor
  initial begin
    int cnt = -1, rises = 0, gapc = 0;
    bit last_s = 0, last_cs = 1, last_d = 0, seen = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (adc_cs_n) begin
          cnt = -1;
          gapc++;
          if (!last_cs) begin
            if (rises != 24) err_rises++;
            rises = 0;
          end
        end else begin
          if (last_cs) begin
            cs_falls++;
            if (seen && gapc < 2 * GAPC * HD) err_gap++;
            seen = 1; gapc = 0;
          end
          cnt++;
          if (adc_sclk != last_s) begin
            if (cnt != HD) err_half++;
            cnt = 0;
            if (adc_sclk) rises++;
          end
          if (adc_sclk && last_s && adc_sdo != last_d) err_sdo++;
        end
      end
      last_s = adc_sclk; last_cs = adc_cs_n; last_d = adc_sdo;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int d, lat, falls0;
    item_t it;
    for (int i = 0; i < NUM_CH; i++) mode_exp[i] = 2'(i ^ 1);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(adc_cs_n == 1'b1, "R1 cs_n after reset", int'(adc_cs_n), 1);
    check(adc_sclk == 1'b0 && adc_sdo == 1'b0, "R1 sclk/sdo after reset",
          int'({adc_sclk, adc_sdo}), 0);
    check(host_ready == 1'b0, "R1 ready after reset", int'(host_ready), 0);
    host_read(16, d, lat);
    check(d == 0, "R1 enable after reset", d, 0);
    host_read(13, d, lat);
    check(d == 0, "R1 mode after reset", d, 0);

    for (int i = 0; i < NUM_CH; i++) host_write(8 + i, int'(mode_exp[i]));
    host_read(10, d, lat);
    check(d == int'(mode_exp[2]), "R2 mode readback", d, int'(mode_exp[2]));
    check(lat == 1, "R7 register read latency", lat, 1);
    repeat (100) @(negedge clk);
    check(cs_falls == 0, "R2 no frame while disabled", cs_falls, 0);

    host_write(16, 1);
    for (int k = 0; k < 9; k++) begin
      while (exp_q.size() == 0) @(negedge clk);
      it = exp_q.pop_front();
      repeat (3) @(negedge clk);
      host_read(it.ch, d, lat);
      check(d == int'(it.val), "R6 stored result", d, int'(it.val));
      if (k == 3) check(lat == 1, "R7 data read latency", lat, 1);
    end

    host_write(it.ch, 16'h0ABC);
    host_read(it.ch, d, lat);
    check(d == int'(it.val), "R11 data write ignored", d, int'(it.val));

    exp_q.delete();
    @(posedge adc_cs_n);
    @(negedge clk);
    it = exp_q.pop_front();
    host_addr = AW'(it.ch); host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; lat = 1;
    while (!host_ready && lat < 10) begin @(negedge clk); lat++; end
    d = int'(host_rdata);
    check(lat == 2, "R8 collision stall", lat, 2);
    check(d == int'(it.val), "R8 collision value", d, int'(it.val));

    exp_q.delete();
    @(negedge adc_cs_n);
    host_write(16, 0);
    lat = 0;
    while (exp_q.size() == 0 && lat < 400) begin @(negedge clk); lat++; end
    check(exp_q.size() == 1, "R9 frame finished after disable", exp_q.size(), 1);
    if (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      host_read(it.ch, d, lat);
      check(d == int'(it.val), "R9 last result stored", d, int'(it.val));
    end
    falls0 = cs_falls;
    repeat (300) @(negedge clk);
    check(cs_falls == falls0 && adc_cs_n, "R9 idle after disable", cs_falls, falls0);

    exp_ch = 0;
    exp_q.delete();
    host_write(16, 1);
    while (exp_q.size() == 0) @(negedge clk);
    it = exp_q.pop_front();
    check(it.ch == 0, "R9 restart at channel 0", it.ch, 0);

    check(err_half == 0, "R10 half period", err_half, 0);
    check(err_rises == 0, "R4 clocks per frame", err_rises, 0);
    check(err_gap == 0, "R4 chip select gap", err_gap, 0);
    check(err_sdo == 0, "R3 data stable while clock high", err_sdo, 0);
    finish_run();
  end

endmodule